// File: doc/BRIEF.md
# Byte-wise Table-Driven CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a stream of bytes and absorbs one byte on every clock in which a byte is presented. The bits of each byte are taken most significant first. Each byte is combined with the high end of the running remainder. The polynomial multiple that reduces the shifted remainder is then read from a remainder table. The table is built during elaboration by constant functions from the polynomial parameter. No memory image is loaded.

A frame opens with a start pulse, which loads the all-ones seed. The start pulse may come in the same cycle as the first byte of the frame. Bytes are then presented with a valid strobe, and the final byte also carries a last flag. One cycle after that final byte, a done pulse marks a result output that already holds the inverted remainder.

A build-time switch selects the table form. The full form uses one 256-entry table indexed by a byte. The small form makes two dependent nibble steps through one 16-entry table. Both forms produce the same result.

Top module: `crc32_bytewise`

## Requirements
- R1: While reset is held and in the first cycle after it, `crc_o` reads 32'h00000000, which is the inverted all-ones seed, and `done_o` is low.
- R2: An accepted byte (`valid_i` high) updates the remainder as if its eight bits, bit 7 first, were fed one at a time into a serial divider with polynomial 32'h04C11DB7. `crc_o` shows the new value one clock later.
- R3: A `start_i` pulse reloads the all-ones seed on the same clock, whether the engine is idle or partway through a frame. With `valid_i` low, `crc_o` reads 32'h00000000 one cycle later. With `valid_i` high, the byte is folded into the fresh seed, and the earlier frame has no effect.
- R4: `crc_o` is always the bitwise inverse of the remainder. For the ASCII message "123456789", `crc_o` reads 32'hFC891918 after the last byte.
- R5: In a cycle with `valid_i` and `start_i` both low, `data_i` and `last_i` are ignored, and `crc_o` keeps its value.
- R6: `done_o` is high for exactly one cycle, and only in the cycle after an accepted byte that had `last_i` high. In that cycle `crc_o` holds the final CRC of the frame.
- R7: With `USE_NIBBLE` set to 1, which selects two 4-bit steps through a 16-entry table, `crc_o` and `done_o` match the 256-entry form cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Reload the all-ones seed at the start of a frame |
| valid_i | input | 1 | `data_i` holds a byte to absorb this cycle |
| last_i | input | 1 | The byte presented is the final byte of the frame |
| data_i | input | 8 | Data byte, bit 7 taken first |
| crc_o | output | 32 | Inverted running remainder |
| done_o | output | 1 | One-cycle pulse after the final byte |

## Verification
The hardest case to reach from the ports is a reload that arrives in the middle of a frame together with a new byte. Here the remainder left behind must be discarded in the same clock that absorbs the byte. The stimulus starts a frame, sends two bytes without a last flag, and then raises start, valid and last together. The result must equal the CRC of that single byte alone. Idle cycles with changing data, and a nibble-form instance checked against the byte form on every sample, cover the ignored inputs and the two table forms.

// File: rtl/crc32_tbl_pkg.sv
package crc32_tbl_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;

  // Run the division loop 'steps' times on a remainder that already holds its input.
  function automatic logic [CRC_W-1:0] crc_shift(input logic [CRC_W-1:0] r,
                                                 input int unsigned steps,
                                                 input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] a;
    a = r;
    for (int unsigned i = 0; i < steps; i++) begin
      a = a[CRC_W-1] ? ((a << 1) ^ poly) : (a << 1);
    end
    return a;
  endfunction

  // Table entry: the remainder of an idx_w-bit message placed at the top.
  function automatic logic [CRC_W-1:0] tbl_entry(input int unsigned idx,
                                                 input int unsigned idx_w,
                                                 input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] seed;
    seed = CRC_W'(idx) << (CRC_W - idx_w);
    return crc_shift(seed, idx_w, poly);
  endfunction

  // Loop form of one byte update, used to cross-check the table path.
  function automatic logic [CRC_W-1:0] crc_serial_byte(input logic [CRC_W-1:0] r,
                                                       input logic [BYTE_W-1:0] d,
                                                       input logic [CRC_W-1:0] poly);
    return crc_shift(r ^ {d, {(CRC_W-BYTE_W){1'b0}}}, BYTE_W, poly);
  endfunction
endpackage

// File: rtl/crc32_lut.sv
module crc32_lut
  import crc32_tbl_pkg::*;
#(
  parameter logic [31:0] POLY  = 32'h04C11DB7,
  parameter int unsigned IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [CRC_W-1:0] val_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [CRC_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign tbl[g] = tbl_entry(g, IDX_W, POLY);
  end

  assign val_o = tbl[idx_i];
endmodule

// File: rtl/crc32_step.sv
module crc32_step
  import crc32_tbl_pkg::*;
#(
  parameter logic [31:0] POLY       = 32'h04C11DB7,
  parameter bit          USE_NIBBLE = 1'b0
) (
  input  logic [CRC_W-1:0]  rem_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  rem_o
);
  localparam int unsigned IDX_W  = USE_NIBBLE ? 4 : 8;
  localparam int unsigned STAGES = BYTE_W / IDX_W;

  logic [CRC_W-1:0] chain [STAGES+1];

  // The byte is merged into the top of the remainder before any reduction.
  assign chain[0] = rem_i ^ {data_i, {(CRC_W-BYTE_W){1'b0}}};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [CRC_W-1:0] cancel_w;
    crc32_lut #(.POLY(POLY), .IDX_W(IDX_W)) lut_i (
      .idx_i (chain[s][CRC_W-1 -: IDX_W]),
      .val_o (cancel_w)
    );
    assign chain[s+1] = (chain[s] << IDX_W) ^ cancel_w;
  end

  assign rem_o = chain[STAGES];
endmodule

// File: rtl/crc32_frame_ctl.sv
module crc32_frame_ctl
  import crc32_tbl_pkg::*;
#(
  parameter logic [31:0] INIT = 32'hFFFFFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CRC_W-1:0] nxt_i,
  input  logic             fin_i,
  output logic [CRC_W-1:0] rem_o,
  output logic             done_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rem_o  <= INIT;
      done_o <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (load_i) rem_o <= nxt_i;
    end
  end
endmodule

// File: rtl/crc32_bytewise.sv
module crc32_bytewise
  import crc32_tbl_pkg::*;
#(
  parameter logic [31:0] POLY       = 32'h04C11DB7,
  parameter logic [31:0] INIT       = 32'hFFFFFFFF,
  parameter logic [31:0] XOR_OUT    = 32'hFFFFFFFF,
  parameter bit          USE_NIBBLE = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        valid_i,
  input  logic        last_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o,
  output logic        done_o
);
  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] base_rem_w;
  logic [CRC_W-1:0] step_rem_w;
  logic [CRC_W-1:0] next_rem_w;
  logic             load_w;
  logic             frame_end_w;

  // A start pulse discards the running remainder in this same cycle.
  assign base_rem_w  = start_i ? INIT : rem_q;
  assign load_w      = start_i | valid_i;
  assign next_rem_w  = valid_i ? step_rem_w : INIT;
  assign frame_end_w = valid_i & last_i;

  crc32_step #(.POLY(POLY), .USE_NIBBLE(USE_NIBBLE)) step_i (
    .rem_i  (base_rem_w),
    .data_i (data_i),
    .rem_o  (step_rem_w)
  );

  crc32_frame_ctl #(.INIT(INIT)) ctl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .nxt_i  (next_rem_w),
    .fin_i  (frame_end_w),
    .rem_o  (rem_q),
    .done_o (done_o)
  );

  assign crc_o = rem_q ^ XOR_OUT;

  // R2 / R7: the table path agrees with the loop form of the divider
  a_r2_table_matches_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> step_rem_w == crc_serial_byte(base_rem_w, data_i, POLY));

  // R3: start without a byte leaves the seed behind
  a_r3_start_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_i) |=> crc_o == (INIT ^ XOR_OUT));

  // R5: no start and no byte means the output holds
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !valid_i) |=> $stable(crc_o));

  // R6: a last byte raises done next cycle, no byte keeps it low
  a_r6_done_follows_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_w |=> done_o);

  a_r6_done_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
endmodule

// File: tb/crc32_bytewise_tb_top.sv
module crc32_bytewise_tb_top;
  localparam logic [31:0] POLY = 32'h04C11DB7;
  localparam int NV = 6;
  // Message bytes sit in the upper LEN bytes, sent most significant byte first.
  localparam logic [31:0] V_MSG  [NV] = '{32'h00000000, 32'hFFFFFFFF, 32'h31323334,
                                          32'h80010000, 32'hA5000000, 32'h00C35A00};
  localparam int          V_LEN  [NV] = '{1, 4, 4, 2, 1, 3};
  localparam bit          V_JOIN [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0, last = 1'b0;
  logic [7:0] data = 8'h00;
  logic [31:0] crc_b, crc_n;
  logic done_b, done_n;
  int checks = 0;
  int errors = 0;
  logic [31:0] ref_rem;

  always #5 clk = ~clk;

  crc32_bytewise #(.USE_NIBBLE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid), .last_i(last),
    .data_i(data), .crc_o(crc_b), .done_o(done_b));

  crc32_bytewise #(.USE_NIBBLE(1'b1)) dut_nib_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid), .last_i(last),
    .data_i(data), .crc_o(crc_n), .done_o(done_n));

  // Independent bit-at-a-time divider: feedback is the top bit XOR the input bit.
  function automatic logic [31:0] ref_byte(input logic [31:0] r, input logic [7:0] d);
    logic [31:0] a;
    logic fb;
    a = r;
    for (int b = 7; b >= 0; b--) begin
      fb = a[31] ^ d[b];
      a = {a[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
    end
    return a;
  endfunction

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [31:0] exp_crc, input logic exp_done);
    chk32(tag, crc_b, exp_crc);
    chk32(tag, {31'b0, done_b}, {31'b0, exp_done});
    chk32({tag, " R7 nibble"}, crc_n, crc_b);
    chk32({tag, " R7 nibble done"}, {31'b0, done_n}, {31'b0, done_b});
  endtask

  task automatic cyc(input logic s, input logic v, input logic l, input logic [7:0] d);
    start = s; valid = v; last = l; data = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    chk_out("R1 during reset", 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1 after reset", 32'h0, 1'b0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      ref_rem = 32'hFFFFFFFF;
      if (!V_JOIN[v]) begin
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        chk_out("R3 start alone", 32'h0, 1'b0);
      end
      for (int i = 0; i < V_LEN[v]; i++) begin
        b = V_MSG[v][31-8*i -: 8];
        ref_rem = ref_byte(ref_rem, b);
        cyc(V_JOIN[v] && i == 0, 1'b1, i == V_LEN[v]-1, b);
        chk_out("R2 R6 vector byte", ~ref_rem, i == V_LEN[v]-1);
      end
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk_out("R6 done one cycle", ~ref_rem, 1'b0);
    end

    // Known check value for "123456789"
    cyc(1'b1, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 9; i++) cyc(i == 0 ? 1'b0 : 1'b0, 1'b1, i == 8, 8'(8'h31 + i));
    chk_out("R4 check value", 32'hFC891918, 1'b1);

    // Idle with changing data and last: ignored
    hold = crc_b;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, i[0], 8'(8'h5A + 37*i));
      chk_out("R5 idle ignored", hold, 1'b0);
    end

    // Mid-frame reload together with a new last byte
    cyc(1'b1, 1'b1, 1'b0, 8'h12);
    cyc(1'b0, 1'b1, 1'b0, 8'h34);
    cyc(1'b1, 1'b1, 1'b1, 8'h9C);
    chk_out("R3 mid-frame start with byte", ~ref_byte(32'hFFFFFFFF, 8'h9C), 1'b1);

    // Mid-frame start without a byte
    cyc(1'b1, 1'b1, 1'b0, 8'h77);
    cyc(1'b1, 1'b0, 1'b0, 8'h88);
    chk_out("R3 mid-frame start alone", 32'h0, 1'b0);

    // Back-to-back last bytes: done stays high on consecutive frames
    cyc(1'b1, 1'b1, 1'b1, 8'h01);
    chk_out("R6 first single-byte frame", ~ref_byte(32'hFFFFFFFF, 8'h01), 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 8'hFE);
    chk_out("R6 second single-byte frame", ~ref_byte(32'hFFFFFFFF, 8'hFE), 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 8'h00);
    chk_out("R6 done drops", ~ref_byte(32'hFFFFFFFF, 8'hFE), 1'b0);

    // Reset in mid-frame returns to the seed
    cyc(1'b0, 1'b1, 1'b0, 8'h44);
    rst_n = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    rst_n = 1'b1;
    chk_out("R1 reset mid-frame", 32'h0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule